// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sorts every memory access into one of three kinds and reports what the access may do. The kinds are a region inside the low legacy window (640 KB up to 1 MB), ordinary system memory under a programmable top-of-memory limit, or an address outside system memory. Inside the window there are nineteen regions of unequal size. Three display regions (64 KB, 32 KB, 32 KB) come first, from A0000h to BFFFFh. Sixteen 16 KB segments follow, from C0000h to FFFFFh. Each region has its own read, write, cacheable and bus-master permission bits. Each display region also has a bit that hands its accesses to the graphics pipeline.

Software programs the regions one at a time through an index and a small data word. It programs the memory limit through a separate write port. Each access presents an address, a direction and a flag that marks an external bus master. One clock later the block returns the permissions, an access-denied flag, a graphics-route flag and an in-memory flag. The memory controller and the cache use these results. Their own behaviour is not part of this block.

Top module: `legacy_window_decoder`

## Requirements
- R1: While reset is held, every output is 0. After reset every region control bit, every graphics-route bit and the top-of-memory limit are 0.
- R2: Each output holds the decode of the access presented on the previous clock. `out_valid` equals `acc_valid` from one cycle earlier.
- R3: The three display regions map to indices 0, 1 and 2: A0000h–AFFFFh is index 0, B0000h–B7FFFh is index 1 and B8000h–BFFFFh is index 2. An address decodes as part of the window only when all address bits at position 20 and above are zero.
- R4: Segment n, covering C0000h + n·16 KB to C0000h + (n+1)·16 KB − 1 for n = 0..15, is index 3 + n.
- R5: The `cfg_attr` encoding is bit 0 read, bit 1 write, bit 2 cacheable and bit 3 bus-master. For an address in the window, `out_rd_ok`, `out_wr_ok`, `out_cache` and `out_master_ok` show the stored bits of the region that was hit.
- R6: `out_gfx` is 1 only for an access to a display region whose stored graphics bit is 1. A `cfg_gfx` value written to a segment index is discarded.
- R7: For an access in memory, `out_denied` is 1 in three cases: a read to a region with read clear, a write to a region with write clear, or a bus-master access to a region with bus-master clear.
- R8: An access routed to the graphics pipeline never reports `out_denied`.
- R9: Outside the window, an address below the limit has `out_in_mem` set and all four permission bits set. An address at or above the limit has every output bit 0 except `out_valid`.
- R10: Addresses in the window have `out_in_mem` set whatever the limit value is.
- R11: A region write with an index of 19 or more changes no region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region control write strobe |
| cfg_idx | input | IDX_W (5) | Region index for the write |
| cfg_attr | input | 4 | Permission bits: {master, cache, write, read} |
| cfg_gfx | input | 1 | Graphics-route bit (stored for display regions only) |
| tom_we | input | 1 | Top-of-memory write strobe |
| tom_data | input | ADDR_W | New top-of-memory limit |
| acc_valid | input | 1 | Access present |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_master | input | 1 | Access comes from an external bus master |
| out_valid | output | 1 | Decode result valid |
| out_rd_ok | output | 1 | Read permitted |
| out_wr_ok | output | 1 | Write permitted |
| out_cache | output | 1 | Cacheable |
| out_master_ok | output | 1 | External master access permitted |
| out_denied | output | 1 | Access breaks a permission |
| out_gfx | output | 1 | Access routed to the graphics pipeline |
| out_in_mem | output | 1 | Access targets system memory |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 16 KB segment shift, which gives sixteen segments and nineteen regions. With 32 bits, addresses above 1 MB can be formed that repeat the window's low 20 bits. These addresses check that the upper-bit qualification keeps them out of the window. They also let the memory limit sit well above the window, so both sides of the limit can be tested. The nineteen-region count leaves indices 19 to 31 unused inside the 5-bit index. Writes to those indices exercise the out-of-range discard.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
   // permission bits of one region, packed in cfg_attr order
   typedef struct packed {
      logic mst;
      logic cache;
      logic wr;
      logic rd;
   } lrd_attr_t;

   localparam int NUM_DISP    = 3;
   localparam int WIN_TOP_BIT = 20;   // window lies below 1 MB
   localparam int SEGS_TOP    = 18;   // segment area spans 2^18 bytes
endpackage

// File: rtl/lrd_region_map.sv
module lrd_region_map
   import lrd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SEG_SHIFT = 14,
   parameter int IDX_W     = 5
)(
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_disp,
   output logic              hit_seg,
   output logic [IDX_W-1:0]  idx
);
   localparam int SEG_W = SEGS_TOP - SEG_SHIFT;

   logic upper_zero;
   logic [SEG_W-1:0] seg_num;

   assign upper_zero = (addr[ADDR_W-1:WIN_TOP_BIT] == '0);
   assign hit_disp   = upper_zero && (addr[19:17] == 3'b101);
   assign hit_seg    = upper_zero && (addr[19:18] == 2'b11);
   assign seg_num    = addr[SEGS_TOP-1:SEG_SHIFT];

   always_comb begin
      if (hit_seg)
         idx = IDX_W'(NUM_DISP) + IDX_W'(seg_num);
      else if (!addr[16])
         idx = IDX_W'(0);
      else if (!addr[15])
         idx = IDX_W'(1);
      else
         idx = IDX_W'(2);
   end
endmodule

// File: rtl/lrd_attr_bank.sv
module lrd_attr_bank
   import lrd_pkg::*;
#(
   parameter int NUM_REG = 19,
   parameter int IDX_W   = 5
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] wr_idx,
   input  lrd_attr_t        wr_attr,
   input  logic             wr_gfx,
   input  logic [IDX_W-1:0] rd_idx,
   output lrd_attr_t        rd_attr,
   output logic             rd_gfx
);
   lrd_attr_t bank  [NUM_REG];
   logic      gfx_q [NUM_REG];

   for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank[r] <= '0;
         else if (we && wr_idx == IDX_W'(r))
            bank[r] <= wr_attr;
      end
      if (r < NUM_DISP) begin : g_gfx
         always_ff @(posedge clk) begin
            if (!rst_n)
               gfx_q[r] <= 1'b0;
            else if (we && wr_idx == IDX_W'(r))
               gfx_q[r] <= wr_gfx;
         end
      end else begin : g_nogfx
         assign gfx_q[r] = 1'b0;
      end
   end

   always_comb begin
      rd_attr = '0;
      rd_gfx  = 1'b0;
      for (int r = 0; r < NUM_REG; r++) begin
         if (rd_idx == IDX_W'(r)) begin
            rd_attr = bank[r];
            rd_gfx  = gfx_q[r];
         end
      end
   end
endmodule

// File: rtl/legacy_window_decoder.sv
module legacy_window_decoder
   import lrd_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SEG_SHIFT = 14,
   localparam int NUM_REG  = NUM_DISP + (1 << (SEGS_TOP - SEG_SHIFT)),
   localparam int IDX_W    = $clog2(NUM_REG)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [3:0]        cfg_attr,
   input  logic              cfg_gfx,
   input  logic              tom_we,
   input  logic [ADDR_W-1:0] tom_data,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_write,
   input  logic              acc_master,
   output logic              out_valid,
   output logic              out_rd_ok,
   output logic              out_wr_ok,
   output logic              out_cache,
   output logic              out_master_ok,
   output logic              out_denied,
   output logic              out_gfx,
   output logic              out_in_mem
);
   if (ADDR_W <= WIN_TOP_BIT) begin : g_chk_addr
      $error("ADDR_W must exceed 20");
   end
   if (SEG_SHIFT < 12 || SEG_SHIFT > 17) begin : g_chk_seg
      $error("SEG_SHIFT must lie in 12..17");
   end

   logic [ADDR_W-1:0] tom_q;
   logic              hit_disp, hit_seg, in_win, below_tom;
   logic [IDX_W-1:0]  reg_idx;
   lrd_attr_t         bank_attr, eff_attr;
   logic              bank_gfx, route_gfx, in_mem, deny;

   always_ff @(posedge clk) begin
      if (!rst_n)      tom_q <= '0;
      else if (tom_we) tom_q <= tom_data;
   end

   lrd_region_map #(.ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT), .IDX_W(IDX_W)) u_map (
      .addr     (acc_addr),
      .hit_disp (hit_disp),
      .hit_seg  (hit_seg),
      .idx      (reg_idx)
   );

   lrd_attr_bank #(.NUM_REG(NUM_REG), .IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wr_idx  (cfg_idx),
      .wr_attr (lrd_attr_t'(cfg_attr)),
      .wr_gfx  (cfg_gfx),
      .rd_idx  (reg_idx),
      .rd_attr (bank_attr),
      .rd_gfx  (bank_gfx)
   );

   assign in_win    = hit_disp | hit_seg;
   assign below_tom = acc_addr < tom_q;
   assign in_mem    = in_win | below_tom;
   assign route_gfx = hit_disp & bank_gfx;

   always_comb begin
      if (in_win)         eff_attr = bank_attr;
      else if (below_tom) eff_attr = '1;
      else                eff_attr = '0;
   end

   assign deny = in_mem & ~route_gfx &
                 ((~acc_write & ~eff_attr.rd) |
                  ( acc_write & ~eff_attr.wr) |
                  ( acc_master & ~eff_attr.mst));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_rd_ok     <= 1'b0;
         out_wr_ok     <= 1'b0;
         out_cache     <= 1'b0;
         out_master_ok <= 1'b0;
         out_denied    <= 1'b0;
         out_gfx       <= 1'b0;
         out_in_mem    <= 1'b0;
      end else begin
         out_valid     <= acc_valid;
         out_rd_ok     <= eff_attr.rd;
         out_wr_ok     <= eff_attr.wr;
         out_cache     <= eff_attr.cache;
         out_master_ok <= eff_attr.mst;
         out_denied    <= deny;
         out_gfx       <= route_gfx;
         out_in_mem    <= in_mem;
      end
   end
endmodule

// File: rtl/lrd_checker.sv
module lrd_checker (
   input logic clk,
   input logic rst_n,
   input logic acc_valid,
   input logic out_valid,
   input logic out_rd_ok,
   input logic out_wr_ok,
   input logic out_cache,
   input logic out_master_ok,
   input logic out_denied,
   input logic out_gfx,
   input logic out_in_mem
);
   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> out_valid);

   assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !out_valid);

   assert_deny_in_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_denied |-> out_in_mem);

   assert_gfx_no_deny_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_gfx |-> !out_denied);

   assert_outside_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_in_mem |-> !(out_rd_ok || out_wr_ok || out_cache || out_master_ok || out_gfx));

   assert_gfx_in_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_gfx |-> out_in_mem);
endmodule

bind legacy_window_decoder lrd_checker u_chk (.*);

// File: tb/legacy_window_decoder_test.sv
module legacy_window_decoder_test;
   localparam int AW = 32;
   localparam int NV = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [4:0]    cfg_idx = '0;
   logic [3:0]    cfg_attr = '0;
   logic          cfg_gfx = 1'b0;
   logic          tom_we = 1'b0;
   logic [AW-1:0] tom_data = '0;
   logic          acc_valid = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic          acc_write = 1'b0;
   logic          acc_master = 1'b0;
   logic out_valid, out_rd_ok, out_wr_ok, out_cache, out_master_ok;
   logic out_denied, out_gfx, out_in_mem;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   legacy_window_decoder uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_attr(cfg_attr), .cfg_gfx(cfg_gfx), .tom_we(tom_we), .tom_data(tom_data),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
      .acc_master(acc_master), .out_valid(out_valid), .out_rd_ok(out_rd_ok),
      .out_wr_ok(out_wr_ok), .out_cache(out_cache), .out_master_ok(out_master_ok),
      .out_denied(out_denied), .out_gfx(out_gfx), .out_in_mem(out_in_mem)
   );

   // result packing {in_mem, gfx, denied, master, cache, write, read}
   function automatic logic [6:0] result();
      return {out_in_mem, out_gfx, out_denied, out_master_ok, out_cache, out_wr_ok, out_rd_ok};
   endfunction

   // vector: {addr, write, master, expected}
   localparam logic [40:0] VEC [NV] = '{
      {32'h000A0000, 1'b0, 1'b0, 7'b1100001},  // R3 R6 region 0 read, gfx
      {32'h000AFFFF, 1'b1, 1'b0, 7'b1100001},  // R8 write to read-only gfx region
      {32'h000B0000, 1'b0, 1'b0, 7'b1000011},  // R3 region 1
      {32'h000B7FFF, 1'b1, 1'b1, 7'b1010011},  // R7 master without master bit
      {32'h000B8000, 1'b0, 1'b0, 7'b1010000},  // R3 region 2 read denied
      {32'h000BFFFF, 1'b1, 1'b0, 7'b1010000},  // R7 write denied
      {32'h000C0000, 1'b1, 1'b1, 7'b1001111},  // R4 segment 0 full
      {32'h000C3FFF, 1'b0, 1'b0, 7'b1001111},  // R4 segment 0 end
      {32'h000C4000, 1'b0, 1'b0, 7'b1010000},  // R4 segment 1 empty
      {32'h000DC000, 1'b1, 1'b0, 7'b1010101},  // R5 R7 read+cache, write denied
      {32'h000DFFFF, 1'b0, 1'b0, 7'b1000101},  // R5 segment 7 end
      {32'h000D8000, 1'b0, 1'b0, 7'b1010000},  // R4 segment 6 empty
      {32'h000FC000, 1'b1, 1'b1, 7'b1001011},  // R6 gfx ignored on segment 15
      {32'h000FFFFF, 1'b0, 1'b0, 7'b1001011},  // R4 last byte
      {32'h0009FFFF, 1'b0, 1'b1, 7'b1001111},  // R9 below window
      {32'h00000000, 1'b1, 1'b0, 7'b1001111},  // R9 address zero
      {32'h00FFFFFF, 1'b0, 1'b0, 7'b1001111},  // R9 just under limit
      {32'h01000000, 1'b0, 1'b1, 7'b0000000},  // R9 at limit
      {32'h00100000, 1'b1, 1'b1, 7'b1001111},  // R9 at 1 MB
      {32'h001A0000, 1'b0, 1'b0, 7'b1001111}   // R3 alias above 1 MB not window
   };

   task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic access(input logic [AW-1:0] a, input logic w, input logic m);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_master = m;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic write_region(input int idx, input logic [3:0] attr, input logic gfx);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_attr = attr; cfg_gfx = gfx;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic write_tom(input logic [AW-1:0] v);
      @(negedge clk);
      tom_we = 1'b1; tom_data = v;
      @(negedge clk);
      tom_we = 1'b0;
   endtask

   initial begin
      acc_valid = 1'b1; acc_addr = 32'h000A0000;
      repeat (3) @(negedge clk);
      check("R1 outputs during reset", {out_valid, result()} , 8'h00);
      acc_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid low after reset", {6'b0, out_valid}, 7'b0);

      access(32'h000A0000, 1'b0, 1'b0);
      check("R1 R10 window bits clear after reset", result(), 7'b1010000);
      access(32'h00000000, 1'b0, 1'b0);
      check("R1 R9 limit zero after reset", result(), 7'b0000000);

      write_region(0,  4'b0001, 1'b1);
      write_region(1,  4'b0011, 1'b0);
      write_region(2,  4'b0000, 1'b0);
      write_region(3,  4'b1111, 1'b0);
      write_region(10, 4'b0101, 1'b0);
      write_region(18, 4'b1011, 1'b1);
      write_tom(32'h01000000);

      for (int i = 0; i < NV; i++) begin
         access(VEC[i][40:9], VEC[i][8], VEC[i][7]);
         check($sformatf("vector %0d R2-latency decode", i), result(), VEC[i][6:0]);
      end

      // R2: valid tracks one cycle behind
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = 32'h000C0000;
      @(negedge clk);
      acc_valid = 1'b0;
      check("R2 valid one cycle later", {6'b0, out_valid}, 7'd1);
      @(negedge clk);
      check("R2 valid drops", {6'b0, out_valid}, 7'd0);

      // R11: out-of-range indices change nothing
      write_region(19, 4'b1111, 1'b1);
      write_region(31, 4'b1111, 1'b1);
      access(32'h000B8000, 1'b0, 1'b0);
      check("R11 region 2 unchanged", result(), 7'b1010000);
      access(32'h000C4000, 1'b0, 1'b0);
      check("R11 region 4 unchanged", result(), 7'b1010000);
      access(32'h000FC000, 1'b0, 1'b0);
      check("R11 region 18 unchanged", result(), 7'b1001011);
      access(32'h000A0000, 1'b0, 1'b0);
      check("R11 region 0 unchanged", result(), 7'b1100001);

      // R10: limit back to zero, window still in memory
      write_tom(32'h0);
      access(32'h000A4000, 1'b1, 1'b0);
      check("R10 window ignores limit", result(), 7'b1100001);
      access(32'h000C0000, 1'b0, 1'b1);
      check("R10 segment ignores limit", result(), 7'b1001111);
      access(32'h00001000, 1'b0, 1'b0);
      check("R9 R10 low memory now outside", result(), 7'b0000000);
      access(32'h001C0000, 1'b0, 1'b0);
      check("R3 alias outside with zero limit", result(), 7'b0000000);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule